// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a group of peripheral request lines and a CPU. Every source carries a 3-bit urgency level, where a smaller number means more urgent. The block latches incoming request pulses as pending flags and picks the most urgent pending source. It raises a request to the CPU only when that level is strictly more urgent than the current mask and the global enable is set. When the CPU acknowledges, the block pushes the old mask onto an internal stack and loads the accepted level as the new mask, so that only more urgent work can pre-empt the running handler. A return strobe pops the stack and gives the interrupted handler its mask back.

A source can also be flagged for transfer-engine service. Such a winner is started directly, with no CPU handshake and no change to the mask. It then holds off every other CPU request and transfer start until the engine reports completion. Level 7 is reserved and is never accepted.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A pulse on `req_i[i]` sets a pending flag for source i. `lvl_i[3*i+2:3*i]` holds that source's level, and 0 is the most urgent. Among pending sources below level 7, `irq_id_o` and `irq_lvl_o` report the most urgent one, and a tie goes to the lowest index.
- R2: A pending source at level 7 never raises `irq_o`, never starts a transfer and is never accepted.
- R3: `irq_o` is high only while the winning level is numerically lower than `mask_o`. A request at the same level as the mask, or a less urgent one, stays pending.
- R4: If `ack_i` is high at a clock edge while `irq_o` is high, then in the next cycle `acc_o` is high for one cycle with `acc_id_o` set to the winner. In that same cycle `mask_o` equals the winner's level, `depth_o` is one higher, and the winner's pending flag is cleared.
- R5: A `ret_i` strobe while `depth_o` is nonzero restores the mask that was saved by the matching acceptance and lowers `depth_o` by one. Nesting reaches at least 7 levels deep.
- R6: `gie_o` loads `gie_d_i` when `gie_we_i` is high. While `gie_o` is 0, `irq_o` stays low and no transfer starts. A mask of 0 also blocks every request.
- R7: If the eligible winner has `xfer_i` set, it is started with no acknowledge. `xfer_start_o` pulses for one cycle with `xfer_id_o`, `xfer_busy_o` rises and `mask_o` is unchanged. While busy, `irq_o` is low and no other transfer starts. `xfer_done_i` ends the service.
- R8: A `ret_i` strobe while `depth_o` is 0 changes neither the mask nor the depth, and it sets `err_o`, which then stays set until reset.
- R9: If `ret_i` and `ack_i` are high in the same cycle, the return is performed and the acknowledge is ignored: no accept pulse occurs and the request stays pending.
- R10: After reset, `mask_o` is 7, `gie_o` is 0, `depth_o` is 0, and `irq_o`, `acc_o`, `xfer_busy_o`, `xfer_start_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Request pulses, one bit per source |
| lvl_i | input | 3*N_SRC | Packed per-source levels |
| xfer_i | input | N_SRC | Per-source transfer-service select |
| gie_we_i | input | 1 | Global enable write strobe |
| gie_d_i | input | 1 | Global enable write value |
| ack_i | input | 1 | CPU accepts the presented request |
| ret_i | input | 1 | CPU handler return strobe |
| xfer_done_i | input | 1 | Transfer engine completion |
| irq_o | output | 1 | Request to the CPU |
| irq_id_o | output | $clog2(N_SRC) | Winning source index |
| irq_lvl_o | output | 3 | Winning source level |
| acc_o | output | 1 | One-cycle accept pulse |
| acc_id_o | output | $clog2(N_SRC) | Accepted source index |
| xfer_start_o | output | 1 | One-cycle transfer start pulse |
| xfer_id_o | output | $clog2(N_SRC) | Source being serviced by the transfer engine |
| xfer_busy_o | output | 1 | Transfer service active |
| gie_o | output | 1 | Global enable state |
| mask_o | output | 3 | Current level mask |
| depth_o | output | $clog2(STK_DEPTH+1) | Mask stack occupancy |
| err_o | output | 1 | Sticky return-underflow flag |

## Verification
The properties assume a well-behaved CPU side. It raises `ack_i` only while `irq_o` is high and issues `ret_i` only to close a handler it actually took, apart from the deliberate empty-stack return. It also pulses `xfer_done_i` only while a transfer is busy. Levels are assumed to stay steady between acceptance and the pulse that reports it. The stimulus drives every handshake from tasks that follow this order. It changes levels only while no accept is in flight, and it breaks the handshake rules in exactly one place, the same-cycle return and acknowledge, which R9 defines.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef logic [2:0] lvl_t;
  localparam lvl_t LVL_OFF = 3'd7;  // reserved, never accepted
endpackage

// File: rtl/nic_arb.sv
module nic_arb
  import nic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend_i,
  input  lvl_t             lvl_i [N_SRC],
  output logic             vld_o,
  output logic [IDX_W-1:0] id_o,
  output lvl_t             lvl_o
);
  // strict compare in ascending index order: ties keep the lower index
  always_comb begin
    vld_o = 1'b0;
    id_o  = '0;
    lvl_o = LVL_OFF;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_i[i] && (lvl_i[i] < lvl_o)) begin
        vld_o = 1'b1;
        id_o  = IDX_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/nic_mask_stack.sv
module nic_mask_stack
  import nic_pkg::*;
#(
  parameter int STK_DEPTH = 8,
  parameter int DEP_W = $clog2(STK_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  lvl_t             push_lvl_i,
  input  logic             pop_i,
  output lvl_t             mask_o,
  output logic [DEP_W-1:0] depth_o,
  output logic             err_o
);
  localparam int PW = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;

  lvl_t             stk_q [STK_DEPTH];
  lvl_t             mask_q;
  logic [DEP_W-1:0] depth_q;
  logic             err_q;
  logic             full, empty;

  assign full  = (depth_q == DEP_W'(STK_DEPTH));
  assign empty = (depth_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= LVL_OFF;
      depth_q <= '0;
      err_q   <= 1'b0;
      for (int i = 0; i < STK_DEPTH; i++) stk_q[i] <= LVL_OFF;
    end else if (pop_i) begin
      if (empty) begin
        err_q <= 1'b1;
      end else begin
        mask_q  <= stk_q[PW'(depth_q - DEP_W'(1))];
        depth_q <= depth_q - DEP_W'(1);
      end
    end else if (push_i && !full) begin
      stk_q[PW'(depth_q)] <= mask_q;
      mask_q              <= push_lvl_i;
      depth_q             <= depth_q + DEP_W'(1);
    end
  end

  assign mask_o  = mask_q;
  assign depth_o = depth_q;
  assign err_o   = err_q;
endmodule

// File: rtl/nic_xfer.sv
module nic_xfer #(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [IDX_W-1:0] id_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             start_o,
  output logic [IDX_W-1:0] id_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      start_o <= 1'b0;
      id_o    <= '0;
    end else begin
      start_o <= go_i && !busy_o;
      if (busy_o) begin
        if (done_i) busy_o <= 1'b0;
      end else if (go_i) begin
        busy_o <= 1'b1;
        id_o   <= id_i;
      end
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int STK_DEPTH = 8,
  localparam int IDX_W    = $clog2(N_SRC),
  localparam int DEP_W    = $clog2(STK_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   req_i,
  input  logic [3*N_SRC-1:0] lvl_i,
  input  logic [N_SRC-1:0]   xfer_i,
  input  logic               gie_we_i,
  input  logic               gie_d_i,
  input  logic               ack_i,
  input  logic               ret_i,
  input  logic               xfer_done_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   irq_id_o,
  output logic [2:0]         irq_lvl_o,
  output logic               acc_o,
  output logic [IDX_W-1:0]   acc_id_o,
  output logic               xfer_start_o,
  output logic [IDX_W-1:0]   xfer_id_o,
  output logic               xfer_busy_o,
  output logic               gie_o,
  output logic [2:0]         mask_o,
  output logic [DEP_W-1:0]   depth_o,
  output logic               err_o
);
  lvl_t             lvl [N_SRC];
  logic [N_SRC-1:0] pend_q, clr;
  logic             win_vld, elig, win_xfer, take, xfer_go, gie_q;
  logic [IDX_W-1:0] win_id;
  lvl_t             win_lvl, mask;

  for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
    assign lvl[g] = lvl_i[3*g +: 3];
  end

  nic_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .pend_i(pend_q), .lvl_i(lvl), .vld_o(win_vld), .id_o(win_id), .lvl_o(win_lvl)
  );

  nic_mask_stack #(.STK_DEPTH(STK_DEPTH), .DEP_W(DEP_W)) u_stk (
    .clk_i, .rst_ni, .push_i(take), .push_lvl_i(win_lvl), .pop_i(ret_i),
    .mask_o(mask), .depth_o(depth_o), .err_o(err_o)
  );

  nic_xfer #(.IDX_W(IDX_W)) u_xfer (
    .clk_i, .rst_ni, .go_i(xfer_go), .id_i(win_id), .done_i(xfer_done_i),
    .busy_o(xfer_busy_o), .start_o(xfer_start_o), .id_o(xfer_id_o)
  );

  assign elig     = win_vld && gie_q && (win_lvl < mask) && !xfer_busy_o;
  assign win_xfer = xfer_i[win_id];
  assign irq_o    = elig && !win_xfer;
  assign take     = irq_o && ack_i && !ret_i;  // return has precedence
  assign xfer_go  = elig && win_xfer;

  always_comb begin
    clr = '0;
    if (take || xfer_go) clr[win_id] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      gie_q    <= 1'b0;
      acc_o    <= 1'b0;
      acc_id_o <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | req_i;
      if (gie_we_i) gie_q <= gie_d_i;
      acc_o <= take;
      if (take) acc_id_o <= win_id;
    end
  end

  assign irq_id_o  = win_id;
  assign irq_lvl_o = win_lvl;
  assign gie_o     = gie_q;
  assign mask_o    = mask;
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
  parameter int STK_DEPTH = 8,
  parameter int DEP_W = $clog2(STK_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             ack_i,
  input logic             ret_i,
  input logic [2:0]       mask_o,
  input logic [DEP_W-1:0] depth_o,
  input logic             acc_o,
  input logic             gie_o,
  input logic             xfer_busy_o,
  input logic             xfer_start_o,
  input logic             xfer_done_i,
  input logic             err_o
);
  p_acc_not_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> (mask_o != 3'd7));
  p_nest_raises_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i && !ret_i) |=> (mask_o < $past(mask_o)));
  p_depth_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DEP_W'(STK_DEPTH));
  p_ret_pops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && depth_o != '0) |=> (depth_o == $past(depth_o) - DEP_W'(1)));
  p_gie_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_o |-> !irq_o);
  p_gie_no_xfer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_o |=> !xfer_start_o);
  p_busy_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_busy_o |-> !irq_o);
  p_no_reentry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_busy_o && !xfer_done_i) |=> !xfer_start_o);
  p_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && depth_o == '0) |=> (err_o && depth_o == '0 && $stable(mask_o)));
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind nest_irq_ctrl nic_chk #(.STK_DEPTH(STK_DEPTH), .DEP_W(DEP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .ack_i(ack_i), .ret_i(ret_i),
  .mask_o(mask_o), .depth_o(depth_o), .acc_o(acc_o), .gie_o(gie_o),
  .xfer_busy_o(xfer_busy_o), .xfer_start_o(xfer_start_o),
  .xfer_done_i(xfer_done_i), .err_o(err_o)
);

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;
  localparam int N = 8;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] req_i = '0, xfer_i = '0;
  logic [3*N-1:0] lvl_i;
  logic gie_we_i = 0, gie_d_i = 0, ack_i = 0, ret_i = 0, xfer_done_i = 0;
  logic irq_o, acc_o, xfer_start_o, xfer_busy_o, gie_o, err_o;
  logic [2:0] irq_id_o, acc_id_o, xfer_id_o, irq_lvl_o, mask_o;
  logic [3:0] depth_o;
  logic [2:0] lv [N];
  int total = 0, fails = 0;

  always #4 clk_i = ~clk_i;
  always_comb for (int i = 0; i < N; i++) lvl_i[3*i +: 3] = lv[i];

  nest_irq_ctrl u0 (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask
  task automatic tick(); @(posedge clk_i); #2; endtask
  task automatic do_reset();
    rst_ni = 0; req_i = '0; xfer_i = '0; ack_i = 0; ret_i = 0;
    gie_we_i = 0; xfer_done_i = 0;
    for (int i = 0; i < N; i++) lv[i] = 3'd7;
    repeat (2) tick(); rst_ni = 1; tick();
  endtask
  task automatic set_gie(logic v); gie_we_i = 1; gie_d_i = v; tick(); gie_we_i = 0; endtask
  task automatic pulse_req(int s); req_i[s] = 1; tick(); req_i = '0; #1; endtask
  task automatic accept(int s, int l);
    lv[s] = 3'(l); pulse_req(s); ack_i = 1; tick(); ack_i = 0; #1;
  endtask
  task automatic do_ret(); ret_i = 1; tick(); ret_i = 0; #1; endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R10 reset state
    do_reset(); #1;
    chk("R10 mask", mask_o, 7); chk("R10 gie", gie_o, 0); chk("R10 depth", depth_o, 0);
    chk("R10 irq", irq_o, 0); chk("R10 acc", acc_o, 0); chk("R10 busy", xfer_busy_o, 0);
    chk("R10 start", xfer_start_o, 0); chk("R10 err", err_o, 0);

    // R6 global enable gating
    lv[0] = 0; pulse_req(0);
    chk("R6 gie0 blocks", irq_o, 0);
    set_gie(1); #1; chk("R6 gie1 irq", irq_o, 1);
    set_gie(0); #1; chk("R6 gie0 again", irq_o, 0);

    // R1/R2 sweep of two sources
    do_reset(); set_gie(1);
    req_i[2] = 1; req_i[5] = 1; tick(); req_i = '0;
    for (int a = 0; a < 8; a++) for (int b = 0; b < 8; b++) begin
      int ev, eid;
      lv[2] = 3'(a); lv[5] = 3'(b); #1;
      ev  = (a < 7 || b < 7) ? 1 : 0;
      eid = (a < 7 && a <= b) ? 2 : 5;
      chk("R2 R1 irq valid", irq_o, ev);
      if (ev == 1) begin
        chk("R1 winner id", irq_id_o, eid);
        chk("R1 winner lvl", irq_lvl_o, (eid == 2) ? a : b);
      end
    end

    // R3/R4/R5 acceptance vs mask
    for (int m = 0; m < 7; m++) begin
      do_reset(); set_gie(1);
      accept(0, m);
      chk("R4 acc pulse", acc_o, 1); chk("R4 acc id", acc_id_o, 0);
      chk("R4 mask", mask_o, m); chk("R4 depth", depth_o, 1);
      tick(); chk("R4 acc one cycle", acc_o, 0);
      req_i[1] = 1; tick(); req_i = '0;
      for (int l = 0; l < 8; l++) begin
        lv[1] = 3'(l); #1;
        chk("R3 R6 strict mask", irq_o, (l < m) ? 1 : 0);
      end
      lv[1] = 3'd7;
      do_ret();
      chk("R5 mask back", mask_o, 7); chk("R5 depth", depth_o, 0);
      chk("R4 pend cleared", irq_o, 0);
    end

    // R5 deep nesting chain
    do_reset(); set_gie(1);
    for (int k = 0; k < 7; k++) begin
      accept(k, 6 - k);
      chk("R5 push mask", mask_o, 6 - k); chk("R5 push depth", depth_o, k + 1);
    end
    for (int k = 6; k >= 0; k--) begin
      do_ret();
      chk("R5 pop mask", mask_o, 7 - k); chk("R5 pop depth", depth_o, k);
    end

    // R8 empty return
    do_ret();
    chk("R8 err", err_o, 1); chk("R8 mask", mask_o, 7); chk("R8 depth", depth_o, 0);
    tick(); tick(); chk("R8 sticky", err_o, 1);

    // R9 return beats ack
    do_reset(); set_gie(1);
    accept(0, 3);
    lv[1] = 1; pulse_req(1);
    chk("R9 irq before", irq_o, 1);
    ack_i = 1; ret_i = 1; tick(); ack_i = 0; ret_i = 0; #1;
    chk("R9 mask", mask_o, 7); chk("R9 depth", depth_o, 0);
    chk("R9 no acc", acc_o, 0); chk("R9 still pending", irq_o, 1);

    // R7 transfer service
    do_reset(); set_gie(1);
    xfer_i[3] = 1; xfer_i[4] = 1; lv[3] = 2;
    pulse_req(3);
    chk("R7 no irq for xfer", irq_o, 0); chk("R7 not yet", xfer_start_o, 0);
    tick();
    chk("R7 start", xfer_start_o, 1); chk("R7 id", xfer_id_o, 3);
    chk("R7 busy", xfer_busy_o, 1); chk("R7 mask kept", mask_o, 7);
    chk("R7 depth kept", depth_o, 0);
    lv[4] = 0; pulse_req(4);
    chk("R7 start one cycle", xfer_start_o, 0);
    lv[1] = 0; pulse_req(1);
    chk("R7 irq held", irq_o, 0); chk("R7 no reentry", xfer_start_o, 0);
    tick(); chk("R7 still busy", xfer_busy_o, 1);
    xfer_done_i = 1; tick(); xfer_done_i = 0; #1;
    chk("R7 released", xfer_busy_o, 0); chk("R7 no start", xfer_start_o, 0);
    chk("R7 R1 tie irq", irq_o, 1); chk("R7 R1 tie id", irq_id_o, 1);
    ack_i = 1; tick(); ack_i = 0; #1;
    chk("R7 cpu accept", acc_id_o, 1); chk("R7 mask0", mask_o, 0);
    tick(); chk("R7 masked xfer", xfer_start_o, 0);
    do_ret(); chk("R7 restore", mask_o, 7);
    tick();
    chk("R7 second start", xfer_start_o, 1); chk("R7 second id", xfer_id_o, 4);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule